// File: doc/BRIEF.md
# Time-Multiplexed Overflow Indicator

This block reports overrange events from a stereo converter on one shared, active-low wired-OR flag. The left and right statuses take turns on the flag, one per frame-clock phase, so a receiver recovers both by latching the flag on the two frame-clock edges. Each overrange pulse marks its channel as overflowed and restarts one shared hold timer, measured in frames. When that timer runs out without a new overrange, both channel statuses clear.

All inputs are sampled on the system clock. The frame clock and the bit clock arrive as ordinary level signals, and the block finds their edges itself. After each frame-clock transition, the flag takes its new value on the first bit-clock rising edge in left-justified format and on the second in I2S format. It then holds that value for the rest of the half-frame, which gives the receiver a wide setup window. The output is a registered pull-down enable for an open-drain pad, together with the logical level the pin would show.

Top module: `ovf_mux_flag`

## Requirements
- R1: While reset is asserted, and after it is released, the pull-down enable is 0 and no channel status is held. Reset acts asynchronously and clears any status that was held before it.
- R2: An overrange pulse on one channel sets that channel's held status. The other channel's status is not changed by it.
- R3: Held statuses clear on the N-th frame-clock rising edge after the last overrange pulse, where N is the reload value. Until that edge, the held statuses stay set.
- R4: An overrange on either channel reloads the one shared hold count. This extends the hold of the other channel's status as well.
- R5: The reload value is taken at the time of the overrange. It is HOLD_FRAMES_A when fam_sel is 0 and HOLD_FRAMES_B when fam_sel is 1.
- R6: With fmt_i2s=0 (left-justified), the frame-clock low phase carries the right status and the high phase carries the left status. With fmt_i2s=1 (I2S), the high phase carries the right status and the low phase carries the left status.
- R7: After a frame-clock transition, the flag keeps its previous value until the update point. The update point is the 1st bit-clock rising edge when fmt_i2s=0 and the 2nd when fmt_i2s=1. At that edge the flag takes the selected channel's status.
- R8: The pull-down enable changes only on a system clock edge that sees a bit-clock rising edge. A status change in the middle of a half-frame does not reach the flag before the next update point.
- R9: ovf_n is the complement of ovf_pd_en. ovf_pd_en is 1 when overflow is indicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovr_l | input | 1 | Left-channel overrange pulse |
| ovr_r | input | 1 | Right-channel overrange pulse |
| lrck | input | 1 | Frame clock level |
| bclk | input | 1 | Bit clock level |
| fmt_i2s | input | 1 | 0 = left-justified timing, 1 = I2S timing |
| fam_sel | input | 1 | Sample-rate family select for the hold reload |
| ovf_pd_en | output | 1 | Registered pull-down enable for the open-drain pad |
| ovf_n | output | 1 | Logical flag level, low when overflow is indicated |

## Verification
A vector table walks half-frames in left-justified format. In it, single left pulses, single right pulses, back-to-back pulses on both channels, and a right pulse followed later by a left pulse separate per-channel setting from the shared restart. The case in which the right status survives only because the later left pulse reloaded the count tells the two apart. Later rows switch to I2S timing and the other family. A check just before the update point and a check just after it pin the one-versus-two bit-clock delay and the swapped phase assignment, while the shorter hold shows which reload was used. Directed cases inject an overrange mid-half-frame to confirm that the flag waits for the next update point, and apply reset while a status is held.

// File: rtl/ovf_mux_pkg.sv
package ovf_mux_pkg;

  typedef enum logic {
    FMT_LEFT_JUST = 1'b0,
    FMT_I2S       = 1'b1
  } frame_fmt_e;

  localparam int unsigned UPD_DLY_W = 2;

  // Bit-clock rising edges between a frame-clock transition and the flag update
  function automatic logic [UPD_DLY_W-1:0] update_delay(input frame_fmt_e fmt);
    return (fmt == FMT_I2S) ? UPD_DLY_W'(2) : UPD_DLY_W'(1);
  endfunction

endpackage

// File: rtl/ovf_clk_sampler.sv
module ovf_clk_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck,
  input  logic bclk,
  output logic lrck_lvl,
  output logic lrck_edge,
  output logic lrck_rise,
  output logic bclk_rise
);

  logic lrck_q;
  logic bclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_q <= 1'b0;
      bclk_q <= 1'b0;
    end else begin
      lrck_q <= lrck;
      bclk_q <= bclk;
    end
  end

  always_comb begin
    lrck_lvl  = lrck_q;
    lrck_edge = lrck ^ lrck_q;
    lrck_rise = lrck & ~lrck_q;
    bclk_rise = bclk & ~bclk_q;
  end

endmodule

// File: rtl/ovf_hold_timer.sv
module ovf_hold_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned HOLD_A = 32634,
  parameter int unsigned HOLD_B = 32640
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovr_l,
  input  logic             ovr_r,
  input  logic             fam_sel,
  input  logic             frame_rise,
  output logic             flag_l,
  output logic             flag_r,
  output logic [CNT_W-1:0] hold_cnt
);

  localparam logic [CNT_W-1:0] RELOAD_A = CNT_W'(HOLD_A);
  localparam logic [CNT_W-1:0] RELOAD_B = CNT_W'(HOLD_B);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic             flag_l_n;
  logic             flag_r_n;
  logic [CNT_W-1:0] cnt_n;
  logic             any_ovr;
  logic             cnt_en;

  always_comb begin
    any_ovr  = ovr_l | ovr_r;
    cnt_en   = frame_rise && (hold_cnt != '0);
    flag_l_n = flag_l;
    flag_r_n = flag_r;
    cnt_n    = hold_cnt;
    if (any_ovr) begin
      cnt_n    = fam_sel ? RELOAD_B : RELOAD_A;
      flag_l_n = flag_l | ovr_l;
      flag_r_n = flag_r | ovr_r;
    end else if (cnt_en) begin
      cnt_n = hold_cnt - CNT_ONE;
      if (hold_cnt == CNT_ONE) begin
        flag_l_n = 1'b0;
        flag_r_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_l   <= 1'b0;
      flag_r   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      flag_l   <= flag_l_n;
      flag_r   <= flag_r_n;
      hold_cnt <= cnt_n;
    end
  end

endmodule

// File: rtl/ovf_phase_mux.sv
module ovf_phase_mux
  import ovf_mux_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fmt_i2s,
  input  logic lrck_lvl,
  input  logic lrck_edge,
  input  logic bclk_rise,
  input  logic flag_l,
  input  logic flag_r,
  output logic pd_en
);

  logic [UPD_DLY_W-1:0] ticks;
  logic [UPD_DLY_W-1:0] ticks_n;
  logic [UPD_DLY_W-1:0] dly;
  logic                 armed;
  logic                 armed_n;
  logic                 pin_n;
  logic                 sel_left;
  logic                 sel_status;

  always_comb begin
    dly        = update_delay(frame_fmt_e'(fmt_i2s));
    sel_left   = lrck_lvl ^ fmt_i2s;
    sel_status = sel_left ? flag_l : flag_r;
    armed_n    = armed;
    ticks_n    = ticks;
    pin_n      = pd_en;
    if (lrck_edge) begin
      armed_n = 1'b1;
      ticks_n = '0;
    end else if (armed && bclk_rise) begin
      if ((ticks + UPD_DLY_W'(1)) == dly) begin
        pin_n   = sel_status;
        armed_n = 1'b0;
      end else begin
        ticks_n = ticks + UPD_DLY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      ticks <= '0;
      pd_en <= 1'b0;
    end else begin
      armed <= armed_n;
      ticks <= ticks_n;
      pd_en <= pin_n;
    end
  end

endmodule

// File: rtl/ovf_mux_flag.sv
module ovf_mux_flag #(
  parameter int unsigned HOLD_FRAMES_A = 32634,
  parameter int unsigned HOLD_FRAMES_B = 32640
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr_l,
  input  logic ovr_r,
  input  logic lrck,
  input  logic bclk,
  input  logic fmt_i2s,
  input  logic fam_sel,
  output logic ovf_pd_en,
  output logic ovf_n
);

  localparam int unsigned HOLD_MAX = (HOLD_FRAMES_A > HOLD_FRAMES_B) ? HOLD_FRAMES_A : HOLD_FRAMES_B;
  localparam int unsigned CNT_W    = $clog2(HOLD_MAX + 1);

  logic             lrck_lvl;
  logic             lrck_edge;
  logic             lrck_rise;
  logic             bclk_rise;
  logic             flag_l;
  logic             flag_r;
  logic [CNT_W-1:0] hold_cnt;
  logic             pd_en;

  ovf_clk_sampler u_smp (
    .clk       (clk),
    .rst_n     (rst_n),
    .lrck      (lrck),
    .bclk      (bclk),
    .lrck_lvl  (lrck_lvl),
    .lrck_edge (lrck_edge),
    .lrck_rise (lrck_rise),
    .bclk_rise (bclk_rise)
  );

  ovf_hold_timer #(
    .CNT_W  (CNT_W),
    .HOLD_A (HOLD_FRAMES_A),
    .HOLD_B (HOLD_FRAMES_B)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovr_l      (ovr_l),
    .ovr_r      (ovr_r),
    .fam_sel    (fam_sel),
    .frame_rise (lrck_rise),
    .flag_l     (flag_l),
    .flag_r     (flag_r),
    .hold_cnt   (hold_cnt)
  );

  ovf_phase_mux u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_i2s   (fmt_i2s),
    .lrck_lvl  (lrck_lvl),
    .lrck_edge (lrck_edge),
    .bclk_rise (bclk_rise),
    .flag_l    (flag_l),
    .flag_r    (flag_r),
    .pd_en     (pd_en)
  );

  assign ovf_pd_en = pd_en;
  assign ovf_n     = ~pd_en;

endmodule

// File: rtl/ovf_mux_flag_chk.sv
module ovf_mux_flag_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned HOLD_A = 32634,
  parameter int unsigned HOLD_B = 32640
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ovr_l,
  input logic             ovr_r,
  input logic             lrck,
  input logic             bclk,
  input logic             fam_sel,
  input logic             ovf_pd_en,
  input logic             flag_l,
  input logic             flag_r,
  input logic [CNT_W-1:0] hold_cnt
);

  logic bclk_prev;
  logic lrck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev <= 1'b0;
      lrck_prev <= 1'b0;
    end else begin
      bclk_prev <= bclk;
      lrck_prev <= lrck;
    end
  end

  AST_SET_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_l |=> flag_l); // R2

  AST_SET_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_r |=> flag_r); // R2

  AST_IDLE_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt == '0) |-> (!flag_l && !flag_r)); // R3

  AST_FRAME_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (lrck && !lrck_prev && !ovr_l && !ovr_r && hold_cnt != '0)
      |=> (hold_cnt == $past(hold_cnt) - CNT_W'(1))); // R3

  AST_RELOAD_ANY_CH: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_l || ovr_r) && !fam_sel) |=> (hold_cnt == CNT_W'(HOLD_A))); // R4

  AST_RELOAD_FAMILY: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovr_l || ovr_r) && fam_sel) |=> (hold_cnt == CNT_W'(HOLD_B))); // R5

  AST_PIN_AT_BCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovf_pd_en) |-> $past(bclk && !bclk_prev)); // R8

endmodule

bind ovf_mux_flag ovf_mux_flag_chk #(
  .CNT_W  (CNT_W),
  .HOLD_A (HOLD_FRAMES_A),
  .HOLD_B (HOLD_FRAMES_B)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ovr_l     (ovr_l),
  .ovr_r     (ovr_r),
  .lrck      (lrck),
  .bclk      (bclk),
  .fam_sel   (fam_sel),
  .ovf_pd_en (ovf_pd_en),
  .flag_l    (flag_l),
  .flag_r    (flag_r),
  .hold_cnt  (hold_cnt)
);

// File: tb/ovf_mux_flag_tb.sv
module ovf_mux_flag_tb;

  localparam int unsigned HOLD_A = 3;
  localparam int unsigned HOLD_B = 2;
  localparam int unsigned BITS_PER_HALF = 32;

  typedef struct packed {
    logic lv;   // frame clock level for this half-frame
    logic il;   // left overrange before the transition
    logic ir;   // right overrange before the transition
    logic fmt;  // 0 left-justified, 1 I2S
    logic fam;  // family select at pulse time
    logic ex;   // expected pull-down enable
  } row_t;

  localparam int NROWS = 32;
  localparam row_t TBL [0:NROWS-1] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b1},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b1},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0},
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0},
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0}
  };

  logic clk;
  logic rst_n;
  logic ovr_l;
  logic ovr_r;
  logic lrck;
  logic bclk;
  logic fmt_i2s;
  logic fam_sel;
  logic ovf_pd_en;
  logic ovf_n;

  int n_cmp;
  int n_bad;
  logic prev_ex;

  ovf_mux_flag #(
    .HOLD_FRAMES_A (HOLD_A),
    .HOLD_FRAMES_B (HOLD_B)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovr_l     (ovr_l),
    .ovr_r     (ovr_r),
    .lrck      (lrck),
    .bclk      (bclk),
    .fmt_i2s   (fmt_i2s),
    .fam_sel   (fam_sel),
    .ovf_pd_en (ovf_pd_en),
    .ovf_n     (ovf_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic pl, input logic pr);
    ovr_l = pl;
    ovr_r = pr;
    wait_neg(1);
    ovr_l = 1'b0;
    ovr_r = 1'b0;
    wait_neg(1);
  endtask

  // One half-frame: optional pulses, frame-clock transition, then bit clocks
  task automatic half_frame(input row_t r, input logic old, input logic mid_l);
    int dly;
    fam_sel = r.fam;
    fmt_i2s = r.fmt;
    if (r.il || r.ir) pulse(r.il, r.ir);
    lrck = r.lv;
    wait_neg(2);
    dly = r.fmt ? 2 : 1;
    for (int k = 1; k <= BITS_PER_HALF; k++) begin
      if (k == dly) chk("R7 before update", ovf_pd_en, old);
      bclk = 1'b1;
      wait_neg(2);
      bclk = 1'b0;
      wait_neg(2);
      if (k == dly) chk("R6 R7 at update", ovf_pd_en, r.ex);
      if (mid_l && k == 16) pulse(1'b1, 1'b0);
    end
    chk("R8 end of half-frame", ovf_pd_en, r.ex);
    chk("R9 complement", ovf_n, ~r.ex);
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    row_t d;
    n_cmp   = 0;
    n_bad   = 0;
    rst_n   = 1'b0;
    ovr_l   = 1'b0;
    ovr_r   = 1'b0;
    lrck    = 1'b0;
    bclk    = 1'b0;
    fmt_i2s = 1'b0;
    fam_sel = 1'b0;
    wait_neg(4);
    chk("R1 reset pull-down", ovf_pd_en, 1'b0);
    chk("R1 reset flag", ovf_n, 1'b1);
    rst_n = 1'b1;
    wait_neg(3);
    chk("R1 after release", ovf_pd_en, 1'b0);

    // R2 R3 R4 R5 R6 R7: table walk
    prev_ex = 1'b0;
    for (int i = 0; i < NROWS; i++) begin
      half_frame(TBL[i], prev_ex, 1'b0);
      prev_ex = TBL[i].ex;
    end

    // R8: overrange mid half-frame must wait for next update point
    d = '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0};
    half_frame(d, 1'b0, 1'b1);
    d = '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1};
    half_frame(d, 1'b0, 1'b0);

    // R1: reset while a status is held
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", ovf_pd_en, 1'b0);
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(2);
    d = '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0};
    half_frame(d, 1'b0, 1'b0);
    d = '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0};
    half_frame(d, 1'b0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule